// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register file of a small processor core. Software sees sixteen 32-bit registers, R0 to R15. Behind that view the block holds extra physical copies of some registers for each of four processor modes. An interrupt or exception handler that runs in its own mode therefore works in its own copies and leaves the interrupted context untouched. No save, restore or copy step takes place when the mode changes.

The block has one mode input, two combinational read ports and one write port that commits on the clock edge. Each port carries a 4-bit architectural index. A small mapper turns that index and the current mode into a physical word address. All physical words sit in one flat array, which a synchronous reset clears.

Mode-change control, status saving, program-counter arithmetic and result forwarding are handled outside this block.

Top module: `banked_regfile`

## Requirements
- R1: R0 to R7 and R15 each have one physical copy. A value written to one of them in any mode is read back in every mode.
- R2: The mode input is encoded as 00 = user, 01 = fast interrupt, 10 = interrupt, 11 = supervisor. In fast-interrupt mode, R8 to R12 address copies that belong only to that mode.
- R3: In fast-interrupt mode, R13 and R14 also address copies that belong only to that mode.
- R4: Interrupt mode and supervisor mode each own a private R13 and R14. In those two modes, R8 to R12 resolve to the user copies.
- R5: A write to a banked register in one mode never changes that register's copy in any other mode. After leaving a mode and entering it again, a read returns the value last written in that mode.
- R6: A change of the mode input changes what the read ports return in the same cycle, with no clock edge in between and no copying of data.
- R7: When write enable is high at a rising clock edge, the data is stored in the physical register chosen by the mode and index present at that edge. The value is readable from the following cycle. When write enable is low, no register changes.
- R8: A read of the register being written in the same cycle returns the value held before that write, because there is no internal bypass.
- R9: The two read ports are independent and combinational. Each port returns the register its own index selects in the current mode.
- R10: While the synchronous active-high reset is high at a clock edge, all 27 physical registers clear to zero, and any write in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes and reset act on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Current processor mode (00 user, 01 fast interrupt, 10 interrupt, 11 supervisor) |
| ra_idx_i | input | 4 | Architectural index for read port A |
| ra_data_o | output | 32 | Read data of port A |
| rb_idx_i | input | 4 | Architectural index for read port B |
| rb_data_o | output | 32 | Read data of port B |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Architectural index for the write port |
| wr_data_i | input | 32 | Write data |

## Verification
Two functions can fall in the same cycle: a read and a write aimed at the same physical register, and a mode change together with a pending write. The bench drives a write and a read of the same index in one cycle. It requires the old value before the edge and the new value after it, on both read ports, for a shared register and for a banked one. It also moves the mode just after a write edge. It then checks that the copy selected at the edge took the data and that the copy of the new mode did not.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;

    localparam int XLEN      = 32;
    localparam int ARCH_N    = 16;
    localparam int AW        = $clog2(ARCH_N);

    // First architectural index banked by fast-interrupt mode, and the
    // stack/link pair banked by every privileged mode.
    localparam int FIQ_FIRST = 8;
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;

    localparam int FIQ_CNT   = LR_IDX - FIQ_FIRST + 1;
    localparam int PAIR_CNT  = LR_IDX - SP_IDX + 1;

    // Physical layout: user copies first, then each private bank.
    localparam int FIQ_BASE  = ARCH_N;
    localparam int IRQ_BASE  = FIQ_BASE + FIQ_CNT;
    localparam int SVC_BASE  = IRQ_BASE + PAIR_CNT;
    localparam int PHYS_N    = SVC_BASE + PAIR_CNT;
    localparam int PW        = $clog2(PHYS_N);

    typedef enum logic [1:0] {
        MODE_USR = 2'b00,
        MODE_FIQ = 2'b01,
        MODE_IRQ = 2'b10,
        MODE_SVC = 2'b11
    } mode_e;

endpackage

// File: rtl/regbank_map.sv
`timescale 1ns/1ps
module regbank_map
    import regbank_pkg::*;
(
    input  mode_e           mode_i,
    input  logic [AW-1:0]   idx_i,
    output logic [PW-1:0]   phys_o
);

    int  ix;
    logic in_fiq_range;
    logic in_pair_range;

    always_comb begin
        ix            = int'(idx_i);
        in_fiq_range  = (ix >= FIQ_FIRST) && (ix <= LR_IDX);
        in_pair_range = (ix >= SP_IDX) && (ix <= LR_IDX);
        phys_o        = PW'(ix);
        unique case (mode_i)
            MODE_FIQ: if (in_fiq_range)  phys_o = PW'(FIQ_BASE + ix - FIQ_FIRST);
            MODE_IRQ: if (in_pair_range) phys_o = PW'(IRQ_BASE + ix - SP_IDX);
            MODE_SVC: if (in_pair_range) phys_o = PW'(SVC_BASE + ix - SP_IDX);
            default:  ;
        endcase
    end

endmodule

// File: rtl/regbank_store.sv
`timescale 1ns/1ps
module regbank_store
    import regbank_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int WORDS  = PHYS_N,
    localparam int IW    = $clog2(WORDS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [IW-1:0]     wphys_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IW-1:0]     rphys_a_i,
    input  logic [IW-1:0]     rphys_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst_i) begin
            s_d.regs = '0;
        end else if (we_i) begin
            s_d.regs[wphys_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign rdata_a_o = s_q.regs[rphys_a_i];
    assign rdata_b_o = s_q.regs[rphys_b_i];

    // R10: one cycle after reset every word reads zero.
    assert_reset_clear_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (s_q.regs == '0));

    // R7: a committed write lands in the selected word.
    assert_write_commit_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> (s_q.regs[$past(wphys_i)] == $past(wdata_i)));

    // R5: a word not addressed by the write keeps its value.
    for (genvar k = 0; k < WORDS; k++) begin : g_iso
        assert_bank_isolated_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            !(we_i && (wphys_i == IW'(k))) |=> $stable(s_q.regs[k]));
    end

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import regbank_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic [AW-1:0]     ra_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [AW-1:0]     rb_idx_i,
    output logic [DATA_W-1:0] rb_data_o,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam int PORTS = 3;   // read A, read B, write
    localparam int P_RA  = 0;
    localparam int P_RB  = 1;
    localparam int P_WR  = 2;

    mode_e         mode;
    logic [AW-1:0] idx_sel  [PORTS];
    logic [PW-1:0] phys_sel [PORTS];

    assign mode          = mode_e'(mode_i);
    assign idx_sel[P_RA] = ra_idx_i;
    assign idx_sel[P_RB] = rb_idx_i;
    assign idx_sel[P_WR] = wr_idx_i;

    for (genvar p = 0; p < PORTS; p++) begin : g_map
        regbank_map u_map (
            .mode_i (mode),
            .idx_i  (idx_sel[p]),
            .phys_o (phys_sel[p])
        );
    end

    regbank_store #(
        .DATA_W (DATA_W),
        .WORDS  (PHYS_N)
    ) u_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (wr_en_i),
        .wphys_i   (phys_sel[P_WR]),
        .wdata_i   (wr_data_i),
        .rphys_a_i (phys_sel[P_RA]),
        .rphys_b_i (phys_sel[P_RB]),
        .rdata_a_o (ra_data_o),
        .rdata_b_o (rb_data_o)
    );

    // R9: distinct indices in one mode never collapse onto one word.
    assert_ports_distinct_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (ra_idx_i != rb_idx_i) |-> (phys_sel[P_RA] != phys_sel[P_RB]));

    // R7: a write in a mode is seen next cycle when read in the same mode.
    assert_write_visible_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(wr_en_i) && !$past(rst_i) && (mode_i == $past(mode_i)) &&
         (ra_idx_i == $past(wr_idx_i))) |-> (ra_data_o == $past(wr_data_i)));

    // R1: a shared register reads the same across a mode change.
    assert_shared_stable_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(mode_i) && $stable(ra_idx_i) && !$past(wr_en_i) && !$past(rst_i) &&
         ((int'(ra_idx_i) < FIQ_FIRST) || (int'(ra_idx_i) == ARCH_N - 1)))
        |-> $stable(ra_data_o));

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [3:0]  ra_idx, rb_idx, wr_idx;
    logic [31:0] ra_data, rb_data, wr_data;
    logic        wr_en;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] mdl [4][16];

    always #2 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk_i     (clk),
        .rst_i     (rst),
        .mode_i    (mode),
        .ra_idx_i  (ra_idx),
        .ra_data_o (ra_data),
        .rb_idx_i  (rb_idx),
        .rb_data_o (rb_data),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data)
    );

    // Two (mode, index) views name the same storage when this returns 1.
    function automatic bit aliased(int ma, int mb, int ix);
        if (ma == mb) return 1'b1;
        if (ix < 8 || ix == 15) return 1'b1;
        if (ix <= 12) return (ma != 1) && (mb != 1);
        return 1'b0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mdl_write(int m, int ix, logic [31:0] d);
        for (int m2 = 0; m2 < 4; m2++)
            if (aliased(m, m2, ix)) mdl[m2][ix] = d;
    endtask

    task automatic mdl_clear();
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 16; i++) mdl[m][i] = '0;
    endtask

    task automatic do_write(int m, int ix, logic [31:0] d);
        @(negedge clk);
        mode = 2'(m); wr_en = 1'b1; wr_idx = 4'(ix); wr_data = d;
        @(posedge clk);
        mdl_write(m, ix, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, int m, int ix);
        @(negedge clk);
        mode = 2'(m); ra_idx = 4'(ix);
        #1;
        chk(tag, ra_data, mdl[m][ix]);
    endtask

    task automatic t_reset_clear();
        rst = 1'b1; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF; mode = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        mdl_clear();
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 16; i++) rd_chk("R10 reset zero", m, i);
    endtask

    task automatic t_shared();
        for (int i = 0; i < 8; i++) do_write(i % 4, i, 32'h1000_0000 + 32'(i));
        do_write(1, 15, 32'h1500_0015);
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 8; i++) rd_chk("R1 shared low", m, i);
            rd_chk("R1 shared R15", m, 15);
        end
    endtask

    task automatic t_fiq_low();
        for (int i = 8; i <= 12; i++) do_write(0, i, 32'hA000_0000 + 32'(i));
        for (int i = 8; i <= 12; i++) do_write(1, i, 32'hF000_0000 + 32'(i));
        do_write(2, 10, 32'hB000_000A);
        do_write(3, 11, 32'hC000_000B);
        for (int i = 8; i <= 12; i++) begin
            rd_chk("R2 fiq private", 1, i);
            rd_chk("R4 irq sees user", 2, i);
            rd_chk("R4 svc sees user", 3, i);
            rd_chk("R2 user untouched", 0, i);
        end
    endtask

    task automatic t_stack_pairs();
        for (int m = 0; m < 4; m++) begin
            do_write(m, 13, 32'h5D00_0000 + 32'(m));
            do_write(m, 14, 32'h1E00_0000 + 32'(m));
        end
        for (int m = 0; m < 4; m++) begin
            rd_chk("R3 R4 bank R13", m, 13);
            rd_chk("R3 R4 bank R14", m, 14);
        end
    endtask

    task automatic t_return();
        do_write(0, 13, 32'h0000_AAAA);
        do_write(2, 13, 32'h0000_BBBB);
        do_write(3, 14, 32'h0000_CCCC);
        rd_chk("R5 user after irq", 0, 13);
        rd_chk("R5 irq on return", 2, 13);
        rd_chk("R5 svc on return", 3, 14);
        do_write(1, 9, 32'h0000_DDDD);
        rd_chk("R5 user R9 kept", 0, 9);
        rd_chk("R5 fiq R9 kept", 1, 9);
    endtask

    task automatic t_switch();
        @(negedge clk);
        ra_idx = 4'd13; mode = 2'd0;
        #0.5;
        chk("R6 switch usr", ra_data, mdl[0][13]);
        mode = 2'd2;
        #0.5;
        chk("R6 switch irq", ra_data, mdl[2][13]);
        mode = 2'd1;
        #0.5;
        chk("R6 switch fiq", ra_data, mdl[1][13]);
    endtask

    task automatic t_write_mode();
        // mode moves right after the committing edge
        @(negedge clk);
        mode = 2'd2; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h7777_0013;
        @(posedge clk);
        mdl_write(2, 13, 32'h7777_0013);
        #0.5;
        mode = 2'd3; wr_en = 1'b0;
        rd_chk("R7 edge mode got data", 2, 13);
        rd_chk("R7 new mode untouched", 3, 13);
        // disabled write changes nothing
        @(negedge clk);
        mode = 2'd0; wr_en = 1'b0; wr_idx = 4'd4; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        rd_chk("R7 no enable no change", 0, 4);
    endtask

    task automatic t_collide();
        do_write(0, 5, 32'h0000_0A05);
        @(negedge clk);
        mode = 2'd0; wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0000_0B05;
        ra_idx = 4'd5; rb_idx = 4'd5;
        #1;
        chk("R8 old value A", ra_data, 32'h0000_0A05);
        chk("R8 old value B", rb_data, 32'h0000_0A05);
        @(posedge clk);
        mdl_write(0, 5, 32'h0000_0B05);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R7 new value next cycle", ra_data, 32'h0000_0B05);
        // banked register in fast-interrupt mode
        @(negedge clk);
        mode = 2'd1; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h0000_0F14;
        ra_idx = 4'd14; rb_idx = 4'd14;
        #1;
        chk("R8 banked old A", ra_data, mdl[1][14]);
        chk("R8 banked old B", rb_data, mdl[1][14]);
        @(posedge clk);
        mdl_write(1, 14, 32'h0000_0F14);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R8 banked new", rb_data, 32'h0000_0F14);
    endtask

    task automatic t_dual();
        @(negedge clk);
        mode = 2'd1; ra_idx = 4'd13; rb_idx = 4'd8;
        #1;
        chk("R9 port A fiq R13", ra_data, mdl[1][13]);
        chk("R9 port B fiq R8", rb_data, mdl[1][8]);
        mode = 2'd3; ra_idx = 4'd15; rb_idx = 4'd14;
        #0.5;
        chk("R9 port A svc R15", ra_data, mdl[3][15]);
        chk("R9 port B svc R14", rb_data, mdl[3][14]);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; mode = 2'd1; wr_idx = 4'd12; wr_data = 32'h1234_5678;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        mdl_clear();
        rd_chk("R10 mid reset fiq R12", 1, 12);
        rd_chk("R10 mid reset irq R13", 2, 13);
        rd_chk("R10 mid reset usr R5", 0, 5);
        rd_chk("R10 mid reset svc R14", 3, 14);
    endtask

    initial begin
        rst = 1'b1; mode = '0; ra_idx = '0; rb_idx = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        mdl_clear();
        t_reset_clear();
        t_shared();
        t_fiq_low();
        t_stack_pairs();
        t_return();
        t_switch();
        t_write_mode();
        t_collide();
        t_dual();
        t_reset_again();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule